// File: doc/BRIEF.md
# Two-Thread Partitioned Retirement Buffer

This block is the in-order retirement buffer of a core that runs one or two hardware threads at once. Every instruction a thread issues takes one entry, tagged by the entry's index. The entry is marked complete later by tag, and entries leave the buffer in the order they were allocated, up to three per thread per cycle.

The buffer changes its partitioning with the number of running threads. With one thread active, that thread owns the whole storage as one circular queue. With both threads active, the storage is split into two fixed halves. Each half is a separate circular queue with its own head and tail, and it wraps at its own boundary, so a busy thread can never eat into the other thread's half. A thread that is spinning in a pause-style wait still drives its active input high and keeps its half. A halted thread drops its active input and gives its half back.

A change of partitioning waits until the buffer is fully drained. Until then, neither thread can allocate, while completion and retirement go on as usual.

Top module: `rob_two_thread`

## Requirements
- R1: After reset the buffer is in single mode owned by thread 0 and both threads are empty. Thread 0 has alloc_ready_o=1 and full_o=0. Thread 1 has no partition: alloc_ready_o=0 and full_o=1. dual_o is 0.
- R2: In single mode the owning thread gets tags 0,1,...,125 in order, wrapping from 125 to 0. It can hold 126 entries before it reads full.
- R3: In dual mode thread 0 is given tags 0..62 and thread 1 tags 63..125. Each wraps at the end of its own range and reads full at 63 entries.
- R4: A thread whose half is full does not affect the other thread, which stays ready while it has free entries.
- R5: The mode follows thr_active_i. 2'b11 selects dual mode (dual_o=1). 2'b10 gives all entries to thread 1. 2'b01 or 2'b00 gives all entries to thread 0. A thread that keeps its active bit high, even while it only waits, keeps its half.
- R6: When the selected mode differs from the current one, the change takes effect at the first clock edge at which both threads hold zero entries. Until then alloc_ready_o is 0 for both threads, while completion and retirement continue.
- R7: full_o[t] is 1 exactly when the thread's entry count equals its partition size (0 when it has no partition). A request while alloc_ready_o[t] is 0 allocates nothing.
- R8: Each cycle, ret_cnt_o[t] (0..3) counts the run of complete entries starting at the thread's oldest entry, capped at 3 and at the number held. The run stops at the first incomplete entry, and those entries leave at the clock edge.
- R9: A completion (cmpl_vld_i[t] with cmpl_tag_i[t]) marks that entry at the clock edge, so it can count toward retirement from the next cycle on.
- R10: empty_o[t] is 1 exactly when the thread holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_active_i | input | 2 | Per-thread active (1) or halted (0) |
| alloc_req_i | input | 2 | Per-thread allocation request |
| alloc_ready_o | output | 2 | Per-thread allocation accepted this cycle |
| alloc_tag_o | output | 14 | Per-thread tag of the entry to be allocated (7 bits each, thread 1 high) |
| cmpl_vld_i | input | 2 | Per-thread completion strobe |
| cmpl_tag_i | input | 14 | Per-thread completion tag (7 bits each, thread 1 high) |
| ret_cnt_o | output | 4 | Per-thread entries retiring at the coming edge (2 bits each) |
| full_o | output | 2 | Per-thread no free entry in its partition |
| empty_o | output | 2 | Per-thread no entries held |
| dual_o | output | 1 | Buffer is split into two halves |

## Verification
The hardest situation to reach is a mode change that is pending while entries are still in flight. In that state the halted thread still holds a full half of incomplete entries, so both threads must stall, and the new mode may only appear after the last of those entries has retired. Directed steps fill thread 1's half, halt it, check the stall, and then complete its entries one by one until the buffer switches. The random phase flips the active bits rarely while completions keep landing on entries that are still outstanding, so many such drain windows occur, including ones that end on the wrap point of a partition.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    CFG_SOLO0 = 2'd0,
    CFG_SOLO1 = 2'd1,
    CFG_DUAL  = 2'd2
  } cfg_e;
endpackage

// File: rtl/rob_mode_ctl.sv
module rob_mode_ctl
  import rob_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] active_i,
  input  logic       all_empty_i,
  output cfg_e       cfg_o,
  output cfg_e       target_o,
  output logic       pending_o,
  output logic       switch_o
);
  cfg_e cfg_q;

  always_comb begin
    unique case (active_i)
      2'b11:   target_o = CFG_DUAL;
      2'b10:   target_o = CFG_SOLO1;
      default: target_o = CFG_SOLO0;
    endcase
  end

  assign pending_o = (target_o != cfg_q);
  assign switch_o  = pending_o && all_empty_i;
  assign cfg_o     = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_SOLO0;
    else if (switch_o) cfg_q <= target_o;
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_empty_i |=> cfg_q == $past(cfg_q));
endmodule

// File: rtl/rob_part_ctl.sv
module rob_part_ctl #(
  parameter int DEPTH   = 126,
  parameter int RET_MAX = 3,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RC_W   = $clog2(RET_MAX + 1),
  localparam int PW     = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] base_i,
  input  logic [CNT_W-1:0] size_i,
  input  logic             init_i,
  input  logic [TAG_W-1:0] init_base_i,
  input  logic             pending_i,
  input  logic             alloc_req_i,
  input  logic [DEPTH-1:0] done_i,
  output logic             ready_o,
  output logic             fire_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [RC_W-1:0]  ret_cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    lim;

  assign lim = PW'(base_i) + PW'(size_i);

  function automatic logic [TAG_W-1:0] adv(logic [TAG_W-1:0] idx, logic [PW-1:0] k,
                                           logic [PW-1:0] l, logic [CNT_W-1:0] s);
    logic [PW-1:0] v;
    v = PW'(idx) + k;
    if (v >= l) v = v - PW'(s);
    return v[TAG_W-1:0];
  endfunction

  assign full_o  = (cnt_q == size_i);
  assign empty_o = (cnt_q == '0);
  assign ready_o = !pending_i && (cnt_q < size_i);
  assign fire_o  = alloc_req_i && ready_o;
  assign tag_o   = tail_q;

  // oldest-first run of complete entries
  always_comb begin
    logic run;
    logic [TAG_W-1:0] idx;
    run       = 1'b1;
    ret_cnt_o = '0;
    for (int i = 0; i < RET_MAX; i++) begin
      idx = adv(head_q, PW'(i), lim, size_i);
      if (run && (CNT_W'(i) < cnt_q) && done_i[idx]) ret_cnt_o = ret_cnt_o + RC_W'(1);
      else run = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (init_i) begin
      head_q <= init_base_i;
      tail_q <= init_base_i;
      cnt_q  <= '0;
    end else begin
      if (fire_o) tail_q <= adv(tail_q, PW'(1), lim, size_i);
      head_q <= adv(head_q, PW'(ret_cnt_o), lim, size_i);
      cnt_q  <= cnt_q + CNT_W'(fire_o) - CNT_W'(ret_cnt_o);
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= size_i);

  // R3
  tag_in_part_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (PW'(tag_o) >= PW'(base_i)) && (PW'(tag_o) < lim));
endmodule

// File: rtl/rob_two_thread.sv
module rob_two_thread #(
  parameter int DEPTH   = 126,
  parameter int RET_MAX = 3,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RC_W   = $clog2(RET_MAX + 1),
  localparam int HALF   = DEPTH / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         thr_active_i,
  input  logic [1:0]         alloc_req_i,
  output logic [1:0]         alloc_ready_o,
  output logic [2*TAG_W-1:0] alloc_tag_o,
  input  logic [1:0]         cmpl_vld_i,
  input  logic [2*TAG_W-1:0] cmpl_tag_i,
  output logic [2*RC_W-1:0]  ret_cnt_o,
  output logic [1:0]         full_o,
  output logic [1:0]         empty_o,
  output logic               dual_o
);
  import rob_pkg::*;

  cfg_e             cfg, target;
  logic             pending, switch_w;
  logic [1:0]       fire;
  logic [DEPTH-1:0] done_q;

  function automatic logic [TAG_W-1:0] part_base(cfg_e c, int t);
    return (c == CFG_DUAL && t == 1) ? TAG_W'(HALF) : '0;
  endfunction

  function automatic logic [CNT_W-1:0] part_size(cfg_e c, int t);
    if (c == CFG_DUAL) return CNT_W'(HALF);
    if ((t == 0 && c == CFG_SOLO0) || (t == 1 && c == CFG_SOLO1)) return CNT_W'(DEPTH);
    return '0;
  endfunction

  rob_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (thr_active_i),
    .all_empty_i (&empty_o),
    .cfg_o       (cfg),
    .target_o    (target),
    .pending_o   (pending),
    .switch_o    (switch_w)
  );

  assign dual_o = (cfg == CFG_DUAL);

  for (genvar g = 0; g < 2; g++) begin : g_part
    rob_part_ctl #(.DEPTH(DEPTH), .RET_MAX(RET_MAX)) u_part (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .base_i      (part_base(cfg, g)),
      .size_i      (part_size(cfg, g)),
      .init_i      (switch_w),
      .init_base_i (part_base(target, g)),
      .pending_i   (pending),
      .alloc_req_i (alloc_req_i[g]),
      .done_i      (done_q),
      .ready_o     (alloc_ready_o[g]),
      .fire_o      (fire[g]),
      .tag_o       (alloc_tag_o[g*TAG_W +: TAG_W]),
      .ret_cnt_o   (ret_cnt_o[g*RC_W +: RC_W]),
      .full_o      (full_o[g]),
      .empty_o     (empty_o[g])
    );
  end

  // completions set, fresh allocations clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
    end else begin
      for (int t = 0; t < 2; t++)
        if (cmpl_vld_i[t] && cmpl_tag_i[t*TAG_W +: TAG_W] < TAG_W'(DEPTH))
          done_q[cmpl_tag_i[t*TAG_W +: TAG_W]] <= 1'b1;
      for (int t = 0; t < 2; t++)
        if (fire[t]) done_q[alloc_tag_o[t*TAG_W +: TAG_W]] <= 1'b0;
    end
  end

  // R6
  no_alloc_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending |-> alloc_ready_o == 2'b00);
endmodule

// File: tb/sim_rob_two_thread.sv
module sim_rob_two_thread;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  thr_active_i = 2'b01;
  logic [1:0]  alloc_req_i = '0;
  logic [1:0]  alloc_ready_o;
  logic [13:0] alloc_tag_o;
  logic [1:0]  cmpl_vld_i = '0;
  logic [13:0] cmpl_tag_i = '0;
  logic [3:0]  ret_cnt_o;
  logic [1:0]  full_o, empty_o;
  logic        dual_o;

  int total = 0, fails = 0;
  int m_cfg, m_head[2], m_tail[2], m_cnt[2];
  bit m_done[126];
  int obs_ret[2], obs_tag[2];
  bit obs_rdy[2], obs_full[2];

  always #4 clk_i = ~clk_i;

  rob_two_thread u0 (.*);

  function automatic int fsize(int c, int t);
    if (c == 2) return 63;
    return (c == t) ? 126 : 0;
  endfunction
  function automatic int fbase(int c, int t);
    return (c == 2 && t == 1) ? 63 : 0;
  endfunction
  function automatic int ftarget(logic [1:0] a);
    return (a == 2'b11) ? 2 : (a == 2'b10) ? 1 : 0;
  endfunction
  function automatic int nx(int idx, int b, int s, int k);
    int r = idx + k;
    if (r >= b + s) r -= s;
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] act, input logic [1:0] areq,
                     input logic [1:0] cv, input int ct0, input int ct1);
    int tgt, ct[2];
    bit pend, sw;
    int e_ret[2];
    bit e_rdy[2];
    @(negedge clk_i);
    thr_active_i = act; alloc_req_i = areq; cmpl_vld_i = cv;
    cmpl_tag_i = {7'(ct1), 7'(ct0)};
    ct[0] = ct0; ct[1] = ct1;
    #1;
    tgt = ftarget(act);
    pend = (tgt != m_cfg);
    chk(dual_o == (m_cfg == 2), "R5 dual", int'(dual_o), int'(m_cfg == 2));
    for (int t = 0; t < 2; t++) begin
      int sz = fsize(m_cfg, t), b = fbase(m_cfg, t);
      bit run = 1;
      e_rdy[t] = !pend && m_cnt[t] < sz;
      e_ret[t] = 0;
      for (int i = 0; i < 3; i++)
        if (run && i < m_cnt[t] && m_done[nx(m_head[t], b, sz, i)]) e_ret[t]++;
        else run = 0;
      obs_ret[t] = int'(ret_cnt_o[2*t +: 2]);
      obs_tag[t] = int'(alloc_tag_o[7*t +: 7]);
      obs_rdy[t] = alloc_ready_o[t];
      obs_full[t] = full_o[t];
      chk(obs_rdy[t] == e_rdy[t], "R6 R7 ready", int'(obs_rdy[t]), int'(e_rdy[t]));
      chk(obs_full[t] == (m_cnt[t] == sz), "R7 full", int'(obs_full[t]), int'(m_cnt[t] == sz));
      chk(empty_o[t] == (m_cnt[t] == 0), "R10 empty", int'(empty_o[t]), int'(m_cnt[t] == 0));
      if (e_rdy[t]) chk(obs_tag[t] == m_tail[t], "R2 R3 tag", obs_tag[t], m_tail[t]);
      chk(obs_ret[t] == e_ret[t], "R8 R9 retire", obs_ret[t], e_ret[t]);
    end
    sw = pend && m_cnt[0] == 0 && m_cnt[1] == 0;
    for (int t = 0; t < 2; t++) if (cv[t]) m_done[ct[t]] = 1;
    if (sw) begin
      m_cfg = tgt;
      for (int t = 0; t < 2; t++) begin
        m_head[t] = fbase(tgt, t); m_tail[t] = m_head[t]; m_cnt[t] = 0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        int sz = fsize(m_cfg, t), b = fbase(m_cfg, t);
        if (areq[t] && e_rdy[t]) begin
          m_done[m_tail[t]] = 0;
          m_tail[t] = nx(m_tail[t], b, sz, 1);
          m_cnt[t]++;
        end
        m_head[t] = nx(m_head[t], b, sz, e_ret[t]);
        m_cnt[t] -= e_ret[t];
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_cfg = 0;
    for (int t = 0; t < 2; t++) begin m_head[t] = 0; m_tail[t] = 0; m_cnt[t] = 0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 reset state
    cyc(2'b01, 2'b00, 2'b00, 0, 0);
    chk(full_o == 2'b10 && empty_o == 2'b11 && alloc_ready_o == 2'b01 && !dual_o,
        "R1 reset", int'({full_o, empty_o, alloc_ready_o}), 'b101101);

    // R2 fill the whole buffer from thread 0
    for (int i = 0; i < 126; i++) cyc(2'b01, 2'b01, 2'b00, 0, 0);
    cyc(2'b01, 2'b01, 2'b00, 0, 0);
    chk(obs_full[0] && !obs_rdy[0], "R2 R7 full at 126", int'(obs_full[0]), 1);
    for (int i = 0; i < 126; i++) cyc(2'b01, 2'b00, 2'b01, i, 0);
    repeat (10) cyc(2'b01, 2'b00, 2'b00, 0, 0);
    cyc(2'b01, 2'b00, 2'b00, 0, 0);
    chk(obs_tag[0] == 0, "R2 wrap to 0", obs_tag[0], 0);

    // R5 R3 dual mode, thread 1 half
    cyc(2'b11, 2'b00, 2'b00, 0, 0);
    cyc(2'b11, 2'b00, 2'b00, 0, 0);
    chk(dual_o && obs_tag[1] == 63, "R3 R5 dual base", obs_tag[1], 63);
    for (int i = 0; i < 63; i++) cyc(2'b11, 2'b10, 2'b00, 0, 0);
    cyc(2'b11, 2'b10, 2'b00, 0, 0);
    chk(obs_full[1] && obs_rdy[0], "R4 isolation", int'({obs_full[1], obs_rdy[0]}), 3);

    // R8 R9 retire stops at first incomplete
    repeat (4) cyc(2'b11, 2'b01, 2'b00, 0, 0);
    cyc(2'b11, 2'b00, 2'b01, 1, 0);
    cyc(2'b11, 2'b00, 2'b01, 2, 0);
    cyc(2'b11, 2'b00, 2'b00, 0, 0);
    chk(obs_ret[0] == 0, "R8 head incomplete", obs_ret[0], 0);
    cyc(2'b11, 2'b00, 2'b01, 0, 0);
    chk(obs_ret[0] == 0, "R9 not same cycle", obs_ret[0], 0);
    cyc(2'b11, 2'b00, 2'b00, 0, 0);
    chk(obs_ret[0] == 3, "R8 three retire", obs_ret[0], 3);
    cyc(2'b11, 2'b00, 2'b01, 3, 0);
    cyc(2'b11, 2'b00, 2'b00, 0, 0);
    chk(obs_ret[0] == 1, "R8 last one", obs_ret[0], 1);

    // R6 thread 1 halts with a full half outstanding
    cyc(2'b01, 2'b11, 2'b00, 0, 0);
    chk(!obs_rdy[0] && !obs_rdy[1], "R6 stall while pending", int'({obs_rdy[1], obs_rdy[0]}), 0);
    for (int i = 63; i < 126; i++) cyc(2'b01, 2'b01, 2'b10, 0, i);
    repeat (25) cyc(2'b01, 2'b00, 2'b00, 0, 0);
    chk(!dual_o && obs_rdy[0], "R6 R5 back to single", int'(dual_o), 0);

    // random phase
    begin
      logic [1:0] act = 2'b11;
      for (int n = 0; n < 4000; n++) begin
        logic [1:0] rq, cv;
        int ct[2];
        if ($urandom % 150 == 0) act = 2'($urandom);
        for (int t = 0; t < 2; t++) begin
          rq[t] = ($urandom % 10) < 6;
          cv[t] = m_cnt[t] > 0 && ($urandom % 2 == 1);
          ct[t] = cv[t] ? nx(m_head[t], fbase(m_cfg, t), fsize(m_cfg, t),
                             int'($urandom % m_cnt[t])) : 0;
        end
        cyc(act, rq, cv, ct[0], ct[1]);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule